// File: doc/BRIEF.md
# Crosspoint Switch Configuration Controller

This block is the digital control plane of an 8-by-8 crosspoint switch. It holds one 4-bit route field per output. The low three bits of a field name the input that feeds that output, and the top bit switches the output on. The block turns this configuration into 64 switch enables (one per input/output pair) and 8 output-buffer enables. The analog matrix itself is not part of the block.

There are two ways to write the configuration register, and both land in the same 32-bit store. In serial mode, each falling edge of a slow configuration clock shifts one bit in, and the bit leaving the far end is driven on a serial output so that several devices can be chained. In parallel mode, each falling edge writes a 4-bit word into the field chosen by a 3-bit output address and leaves every other field unchanged. A second register holds the configuration that drives the decoders. While the active-low update level is low, it copies the first register on every system clock; while that level is high, it holds. An active-low chip enable gates both the writes and the copying. An asynchronous active-low reset turns every output off at once.

The slow configuration pins are not tied to the system clock. They pass through a two-flop synchroniser, and the falling edge of the configuration clock is detected on the synchronised copy.

Top module: `xpt_cfg_ctrl`

## Requirements
- R1: Output o uses bits 4o+3..4o of the configuration. Bits 4o+2..4o hold an input number i, and bit 4o+3 is the output enable. When the output is enabled, `sw_en[8o+i]` is the only switch enable high in row o (bits 8o+7..8o).
- R2: When bit 4o+3 of the active configuration is 0, `out_en[o]` is low and all eight bits of row o of `sw_en` are low, whatever the input number.
- R3: With `par_sel` low and `ce_n` low, each falling edge of `cfg_clk` shifts `cfg_sdi` into bit 0 and moves every bit up by one. The first of 32 bits ends in bit 31 (the enable of output 7), and the last ends in bit 0. Rising edges of `cfg_clk` change nothing.
- R4: `cfg_sdo` always shows bit 31 of the shift/load register, so after k more serial shifts it shows the bit that was at position 31-k.
- R5: With `par_sel` high and `ce_n` low, a falling edge of `cfg_clk` writes `par_data` into the field selected by `par_addr`, and all other fields keep their values.
- R6: While `upd_n` and `ce_n` are both low, the active configuration follows the register. While `upd_n` is high, the active configuration, `out_en` and `sw_en` hold.
- R7: While `ce_n` is high, falling edges of `cfg_clk` neither shift nor load, and the active configuration is not copied.
- R8: While `rst_n` is low, `out_en` and `sw_en` are zero without waiting for a clock edge. Both registers clear, so every output stays off after release until a new word is written and copied.
- R9: Pin values are captured on each rising edge of `clk`. A pin level captured at edge n acts on the register at edge n+2 (falling-edge detection compares the levels captured at n and n-1). The copy to the active configuration, gated by `upd_n` and `ce_n` as captured at n, also happens at edge n+2 and copies the register as it stood before that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low; turns all outputs off |
| cfg_clk | input | 1 | Configuration clock; acts on its falling edge |
| cfg_sdi | input | 1 | Serial configuration data in |
| upd_n | input | 1 | Low: active configuration follows the register; high: hold |
| ce_n | input | 1 | Chip enable, active low; gates writes and copying |
| par_sel | input | 1 | Low: serial mode; high: parallel mode |
| par_addr | input | 3 | Output selected for a parallel write |
| par_data | input | 4 | Parallel field: bit 3 enables the output, bits 2..0 select the input |
| cfg_sdo | output | 1 | Serial data out (bit 31 of the register), for chaining |
| out_en | output | 8 | Output buffer enables, one per output |
| sw_en | output | 64 | Switch enables; bit 8o+i connects input i to output o |

## Verification
The hardest state to reach is one where the register and the active configuration differ. A full serial load while `upd_n` is high creates that state: the outputs must keep the old routing while `cfg_sdo` already streams the old word out bit by bit. The bench then mixes in a parallel write to a single field and a burst of configuration clocks with `ce_n` high. Each of these must leave every other field, or the whole configuration, untouched. Finally, reset is asserted partway through a system clock period, and the outputs are sampled before the next edge to show that they go off without any clock.

// File: rtl/xpt_cfg_ctrl.sv
module xpt_cfg_ctrl #(
  parameter int SEL_W = 3,
  parameter int N_OUT = 8
) (
  input  logic                                  clk,
  input  logic                                  rst_n,
  input  logic                                  cfg_clk,
  input  logic                                  cfg_sdi,
  input  logic                                  upd_n,
  input  logic                                  ce_n,
  input  logic                                  par_sel,
  input  logic [$clog2(N_OUT)-1:0]              par_addr,
  input  logic [SEL_W:0]                        par_data,
  output logic                                  cfg_sdo,
  output logic [N_OUT-1:0]                      out_en,
  output logic [N_OUT*(1<<SEL_W)-1:0]           sw_en
);
  localparam int FW   = SEL_W + 1;
  localparam int CW   = N_OUT * FW;
  localparam int N_IN = 1 << SEL_W;
  localparam int AW   = $clog2(N_OUT);
  localparam int PW   = 5 + AW + FW;
  localparam logic [PW-1:0] PIN_RST = {1'b0, 1'b0, 1'b1, 1'b1, 1'b0, {AW{1'b0}}, {FW{1'b0}}};

  logic [PW-1:0] pin_now, pin_s1, pin_s2;
  logic          clk_s3;
  logic          c_clk, c_sdi, c_upd_n, c_ce_n, c_par;
  logic [AW-1:0] c_addr;
  logic [FW-1:0] c_data;
  logic          fall;
  logic [CW-1:0] shreg, active;

  assign pin_now = {cfg_clk, cfg_sdi, upd_n, ce_n, par_sel, par_addr, par_data};
  assign {c_clk, c_sdi, c_upd_n, c_ce_n, c_par, c_addr, c_data} = pin_s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_s1 <= PIN_RST;
      pin_s2 <= PIN_RST;
      clk_s3 <= 1'b0;
    end else begin
      pin_s1 <= pin_now;
      pin_s2 <= pin_s1;
      clk_s3 <= c_clk;
    end
  end

  assign fall = clk_s3 & ~c_clk & ~c_ce_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      shreg <= '0;
    else if (fall) begin
      if (c_par)
        shreg[c_addr*FW +: FW] <= c_data;
      else
        shreg <= {shreg[CW-2:0], c_sdi};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      active <= '0;
    else if (!c_upd_n && !c_ce_n)
      active <= shreg;
  end

  assign cfg_sdo = shreg[CW-1];

  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    logic             on;
    logic [SEL_W-1:0] src;
    assign on  = rst_n & active[o*FW + SEL_W];
    assign src = active[o*FW +: SEL_W];
    assign out_en[o] = on;
    for (genvar i = 0; i < N_IN; i++) begin : g_in
      assign sw_en[o*N_IN + i] = on & (src == i[SEL_W-1:0]);
    end
  end
endmodule

// File: rtl/xpt_cfg_ctrl_chk.sv
module xpt_cfg_ctrl_chk #(
  parameter int SEL_W = 3,
  parameter int N_OUT = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        upd_n,
  input logic                        ce_n,
  input logic                        cfg_sdo,
  input logic [N_OUT-1:0]            out_en,
  input logic [N_OUT*(1<<SEL_W)-1:0] sw_en
);
  localparam int N_IN = 1 << SEL_W;

  for (genvar o = 0; o < N_OUT; o++) begin : g_row
    assert_row_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
      out_en[o] |-> $onehot(sw_en[o*N_IN +: N_IN]));
    assert_row_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !out_en[o] |-> (sw_en[o*N_IN +: N_IN] == '0));
  end

  assert_hold_on_update_high_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(upd_n, 3) |-> ($stable(out_en) && $stable(sw_en)));

  assert_ce_blocks_copy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n, 3) |-> $stable(out_en));

  assert_ce_blocks_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ce_n, 3) |-> $stable(cfg_sdo));

  always @(negedge clk) begin
    if (rst_n == 1'b0)
      assert_reset_off_R8: assert (out_en == '0 && sw_en == '0);
  end
endmodule

bind xpt_cfg_ctrl xpt_cfg_ctrl_chk #(.SEL_W(SEL_W), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_n(upd_n), .ce_n(ce_n),
  .cfg_sdo(cfg_sdo), .out_en(out_en), .sw_en(sw_en)
);

// File: tb/tb_xpt_cfg_ctrl.sv
module tb_xpt_cfg_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_clk = 1'b1, cfg_sdi = 1'b0, upd_n = 1'b1, ce_n = 1'b1, par_sel = 1'b0;
  logic [2:0]  par_addr = '0;
  logic [3:0]  par_data = '0;
  logic        cfg_sdo;
  logic [7:0]  out_en;
  logic [63:0] sw_en;

  int tests = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  xpt_cfg_ctrl dut (
    .clk(clk), .rst_n(rst_n), .cfg_clk(cfg_clk), .cfg_sdi(cfg_sdi), .upd_n(upd_n),
    .ce_n(ce_n), .par_sel(par_sel), .par_addr(par_addr), .par_data(par_data),
    .cfg_sdo(cfg_sdo), .out_en(out_en), .sw_en(sw_en)
  );

  function automatic logic [7:0] exp_oe(logic [31:0] w);
    logic [7:0] r;
    for (int o = 0; o < 8; o++) r[o] = w[4*o+3];
    return r;
  endfunction

  function automatic logic [63:0] exp_sw(logic [31:0] w);
    logic [63:0] r = '0;
    for (int o = 0; o < 8; o++)
      if (w[4*o+3]) r[8*o + int'(w[4*o +: 3])] = 1'b1;
    return r;
  endfunction

  // Behavioural reference: queue of captured pin samples (R9 latency)
  typedef struct packed {
    logic ck, sdi, upd, ce, par;
    logic [2:0] addr;
    logic [3:0] data;
  } pins_t;
  localparam pins_t IDLE = '{ck:1'b0, sdi:1'b0, upd:1'b1, ce:1'b1, par:1'b0, addr:3'd0, data:4'd0};
  pins_t hist[$];
  logic [31:0] m_reg = '0, m_act = '0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_reg = '0; m_act = '0;
      hist = '{IDLE, IDLE, IDLE};
    end else begin
      pins_t a, b;
      a = hist[1];
      b = hist[2];
      if (!a.upd && !a.ce) m_act = m_reg;
      if (b.ck && !a.ck && !a.ce) begin
        if (a.par) m_reg[4*a.addr +: 4] = a.data;
        else       m_reg = {m_reg[30:0], a.sdi};
      end
      hist.push_front('{ck:cfg_clk, sdi:cfg_sdi, upd:upd_n, ce:ce_n, par:par_sel,
                        addr:par_addr, data:par_data});
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      tests++;
      if (out_en !== exp_oe(m_act) || sw_en !== exp_sw(m_act) || cfg_sdo !== m_reg[31]) begin
        fails++;
        $display("FAIL R9 model: out_en=%h sw_en=%h sdo=%b exp %h %h %b",
                 out_en, sw_en, cfg_sdo, exp_oe(m_act), exp_sw(m_act), m_reg[31]);
      end
    end
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic pulse_cfg();
    cfg_clk = 1'b0; cyc(3);
    cfg_clk = 1'b1; cyc(3);
  endtask

  task automatic serial_word(logic [31:0] w);
    par_sel = 1'b0;
    for (int i = 31; i >= 0; i--) begin
      cfg_sdi = w[i];
      pulse_cfg();
    end
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] w1, w2, w3;
    logic [7:0]  oe_keep;
    w1 = 32'hF0ABC9E8;
    w2 = 32'h3C5A9F18;
    cyc(4);
    chk("R8 reset state", {out_en, cfg_sdo}, '0);
    rst_n = 1'b1;
    cyc(4);
    ce_n = 1'b0;

    // R3, R6: load while holding, outputs must stay off
    serial_word(w1);
    cyc(4);
    chk("R6 hold during load", out_en, 8'h00);
    chk("R4 sdo after load", cfg_sdo, w1[31]);
    upd_n = 1'b0; cyc(5);
    chk("R3 out_en after serial", out_en, exp_oe(w1));
    chk("R1 sw_en after serial", sw_en, exp_sw(w1));
    chk("R2 output6 row off", sw_en[55:48], 8'h00);
    upd_n = 1'b1; cyc(4);

    // R4: stream w2 in, old word comes out on sdo
    par_sel = 1'b0;
    for (int k = 1; k <= 32; k++) begin
      cfg_sdi = w2[32-k];
      pulse_cfg();
      if (k <= 4) chk("R4 sdo chain", cfg_sdo, w1[31-k]);
    end
    chk("R6 active held during second load", sw_en, exp_sw(w1));
    upd_n = 1'b0; cyc(5);
    chk("R1 sw_en second word", sw_en, exp_sw(w2));

    // R5: parallel write of output 6, others unchanged
    par_sel = 1'b1; par_addr = 3'd6; par_data = 4'b1101;
    pulse_cfg(); cyc(3);
    w3 = w2; w3[27:24] = 4'b1101;
    chk("R5 parallel field write", sw_en, exp_sw(w3));
    par_addr = 3'd0; par_data = 4'b0110;
    pulse_cfg(); cyc(3);
    w3[3:0] = 4'b0110;
    chk("R5 parallel disable output0", sw_en, exp_sw(w3));
    chk("R2 output0 off", out_en[0], 1'b0);

    // R7: chip enable high blocks writes and copy
    ce_n = 1'b1; cyc(4);
    par_addr = 3'd7; par_data = 4'b1111;
    pulse_cfg(); pulse_cfg(); cyc(3);
    chk("R7 no write with ce high", sw_en, exp_sw(w3));
    oe_keep = out_en;
    ce_n = 1'b0; cyc(5);
    chk("R7 nothing stored while disabled", out_en, oe_keep);

    // R8: asynchronous reset mid-cycle
    @(posedge clk); #1 rst_n = 1'b0;
    #1;
    chk("R8 async off", {out_en, sw_en}, '0);
    cyc(2);
    rst_n = 1'b1; cyc(6);
    chk("R8 stays off after release", out_en, 8'h00);
    chk("R8 register cleared", cfg_sdo, 1'b0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule